// File: doc/BRIEF.md
# UART Receive Control-Character Matcher

This block sits behind a UART receiver and inspects every received character against a small programmable table of control characters. A shared bit mask decides which character bits take part in every comparison. When a character hits a table entry, the entry's reject flag picks the action:

- **Reject flag clear:** the character is passed to the receive data stream and the current buffer is closed.
- **Reject flag set:** the character is held back from the data stream and placed in a single capture register. The buffer stays open.

Both actions raise an interrupt pulse. Characters that hit nothing flow into the data stream unchanged.

Software fills the table and the mask through a simple write port. It drains the capture register with a read strobe. The decision for each character is fixed at two clocks after its strobe, whatever the table holds.

Top module: `ctrl_char_matcher`

## Requirements
- R1: After reset, all pulse outputs and `cap_valid`/`cap_ovr` are 0. `cfg_mask` reads 16'hC0FF. Every table entry carries the end flag, so no character matches.
- R2: Bits 15 and 14 of `cfg_mask` always read 1, whatever value was written. The other bits read back as written.
- R3: A write with `cfg_addr` 0..7 loads that entry: `cfg_wdata[15]` is the end flag, `cfg_wdata[14]` the reject flag, and `cfg_wdata[7:0]` the character. `cfg_addr` 8 loads the mask. Writes to addresses 9..15 have no effect.
- R4: An entry whose end flag is set never matches. Entries at higher indices than the first end flag never match either.
- R5: A mask bit in positions 7..0 that is 0 removes that bit from every comparison. A mask bit of 1 requires equality in that position.
- R6: When several valid entries match, the lowest-indexed one decides the action.
- R7: A character matching no valid entry gives `buf_wr`=1 with `buf_data` equal to the character, `buf_close`=0 and `irq`=0.
- R8: A match on an entry with the reject flag clear gives `buf_wr`=1 with the character, `buf_close`=1 and `irq`=1.
- R9: A match on an entry with the reject flag set gives `buf_wr`=0, `buf_close`=0 and `irq`=1. `cap_char` takes the character and `cap_valid` goes to 1.
- R10: A rejected character arriving while `cap_valid` is 1, with no `cap_rd` in that cycle, overwrites `cap_char` and sets the sticky `cap_ovr`.
- R11: `cap_rd` clears `cap_valid` and `cap_ovr`. If a capture lands in the same cycle, `cap_valid` stays 1 with the new character and `cap_ovr` is 0.
- R12: Outputs for a character strobed on clock edge k appear after edge k+2, as one-cycle pulses. Each strobe yields exactly one action: a store, or a divert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | 8 | Received character |
| cfg_we | input | 1 | Table/mask write enable |
| cfg_addr | input | 4 | Write address: 0..7 entries, 8 mask |
| cfg_wdata | input | 16 | Write data |
| cap_rd | input | 1 | Capture register read strobe |
| buf_wr | output | 1 | Write character to receive buffer |
| buf_data | output | 8 | Character for the buffer write |
| buf_close | output | 1 | Close the current receive buffer |
| irq | output | 1 | Control-character interrupt pulse |
| cap_char | output | 8 | Last diverted character |
| cap_valid | output | 1 | Capture register holds an unread character |
| cap_ovr | output | 1 | Capture register was overwritten unread |
| cfg_mask | output | 16 | Current comparison mask |

## Verification
The latency and quiet-output assertions assume `rx_valid` is low during reset. The stimulus holds every input at 0 until reset has been released for several cycles.

They also take for granted that strobes may arrive back to back. The random stimulus spaces them only by the check sampling. Table writes are issued while no character is in flight, so each expected action is computed from a stable table.

Random characters are mostly drawn from table entries with bits flipped only where the mask ignores them. This keeps matches, masked matches, end-marker cutoffs and overwrites of the capture register frequent.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int CHAR_W  = 8;
  localparam int CFG_W   = 16;
  localparam int EOT_BIT = 15;
  localparam int REJ_BIT = 14;

  typedef enum logic [1:0] {
    ACT_STORE  = 2'd0,
    ACT_CLOSE  = 2'd1,
    ACT_DIVERT = 2'd2
  } act_e;
endpackage

// File: rtl/ccm_table.sv
module ccm_table
  import ccm_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int CW     = CHAR_W,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rx_valid,
  input  logic [CW-1:0]     rx_char,
  output logic [CFG_W-1:0]  mask_q,
  output logic              s1_valid,
  output logic [CW-1:0]     s1_char,
  output logic [N_ENT-1:0]  s1_hit,
  output logic [N_ENT-1:0]  s1_rej
);
  localparam logic [CFG_W-1:0] MASK_RST =
    {2'b11, {(CFG_W-2-CW){1'b0}}, {CW{1'b1}}};
  localparam logic [AW-1:0] MASK_ADDR = AW'(N_ENT);

  logic [N_ENT-1:0] ent_eot;
  logic [N_ENT-1:0] ent_rej;
  logic [CW-1:0]    ent_chr [N_ENT];
  logic [N_ENT-1:0] live;
  logic [N_ENT-1:0] hit_c;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_eot[i] <= 1'b1;
        ent_rej[i] <= 1'b0;
        ent_chr[i] <= '0;
      end else if (cfg_we && cfg_addr == AW'(i)) begin
        ent_eot[i] <= cfg_wdata[EOT_BIT];
        ent_rej[i] <= cfg_wdata[REJ_BIT];
        ent_chr[i] <= cfg_wdata[CW-1:0];
      end
    end

    if (i == 0) begin : g_first
      assign live[i] = ~ent_eot[i];
    end else begin : g_rest
      assign live[i] = ~ent_eot[i] & live[i-1];
    end

    assign hit_c[i] = live[i] &
      (((rx_char ^ ent_chr[i]) & mask_q[CW-1:0]) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= MASK_RST;
    end else if (cfg_we && cfg_addr == MASK_ADDR) begin
      mask_q <= {2'b11, cfg_wdata[CFG_W-3:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_char  <= '0;
      s1_hit   <= '0;
      s1_rej   <= '0;
    end else begin
      s1_valid <= rx_valid;
      s1_char  <= rx_char;
      s1_hit   <= rx_valid ? hit_c : '0;
      s1_rej   <= ent_rej;
    end
  end

  // R12: every strobe enters the decision stage on the next cycle
  p_stage_r12: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> s1_valid);

  // R4: an entry behind or at an end flag never reports a hit
  p_dead_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && ent_eot[0]) |=> (s1_hit == '0));
endmodule

// File: rtl/ccm_pick.sv
module ccm_pick
  import ccm_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int CW    = CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [CW-1:0]     s1_char,
  input  logic [N_ENT-1:0]  s1_hit,
  input  logic [N_ENT-1:0]  s1_rej,
  output logic              buf_wr,
  output logic [CW-1:0]     buf_data,
  output logic              buf_close,
  output logic              irq,
  output logic              cap_load,
  output logic [CW-1:0]     cap_data
);
  act_e act;
  logic any_hit;
  logic sel_rej;

  always_comb begin
    any_hit = 1'b0;
    sel_rej = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (s1_hit[i]) begin
        any_hit = 1'b1;
        sel_rej = s1_rej[i];
      end
    end
    if (!any_hit)     act = ACT_STORE;
    else if (sel_rej) act = ACT_DIVERT;
    else              act = ACT_CLOSE;
  end

  assign cap_load = s1_valid && (act == ACT_DIVERT);
  assign cap_data = s1_char;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_wr    <= 1'b0;
      buf_data  <= '0;
      buf_close <= 1'b0;
      irq       <= 1'b0;
    end else begin
      buf_wr    <= s1_valid && (act != ACT_DIVERT);
      buf_data  <= s1_char;
      buf_close <= s1_valid && (act == ACT_CLOSE);
      irq       <= s1_valid && (act != ACT_STORE);
    end
  end

  // R8: a close always comes with the store and the interrupt
  p_close_store_r8: assert property (@(posedge clk) disable iff (rst)
    buf_close |-> (buf_wr && irq));

  // R12: nothing pulses without a character in the decision stage
  p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> (!buf_wr && !irq));

  // R9: a divert never also writes the buffer
  p_divert_r9: assert property (@(posedge clk) disable iff (rst)
    cap_load |=> (irq && !buf_wr && !buf_close));
endmodule

// File: rtl/ccm_capture.sv
module ccm_capture
  import ccm_pkg::*;
#(
  parameter int CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] data,
  input  logic          rd,
  output logic [CW-1:0] cap_char,
  output logic          cap_valid,
  output logic          cap_ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_char  <= '0;
      cap_valid <= 1'b0;
      cap_ovr   <= 1'b0;
    end else begin
      if (load) cap_char <= data;
      cap_valid <= load | (cap_valid & ~rd);
      cap_ovr   <= ~rd & (cap_ovr | (load & cap_valid));
    end
  end

  // R10: an unread overwrite raises the overrun flag
  p_ovr_set_r10: assert property (@(posedge clk) disable iff (rst)
    (load && cap_valid && !rd) |=> cap_ovr);

  // R10: the newest diverted character is the one held
  p_newest_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> (cap_valid && cap_char == $past(data)));

  // R11: a read with no capture empties the register
  p_rd_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (rd && !load) |=> (!cap_valid && !cap_ovr));
endmodule

// File: rtl/ctrl_char_matcher.sv
module ctrl_char_matcher
  import ccm_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int CW    = CHAR_W,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CW-1:0]     rx_char,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cap_rd,
  output logic              buf_wr,
  output logic [CW-1:0]     buf_data,
  output logic              buf_close,
  output logic              irq,
  output logic [CW-1:0]     cap_char,
  output logic              cap_valid,
  output logic              cap_ovr,
  output logic [CFG_W-1:0]  cfg_mask
);
  logic              s1_valid;
  logic [CW-1:0]     s1_char;
  logic [N_ENT-1:0]  s1_hit;
  logic [N_ENT-1:0]  s1_rej;
  logic              cap_load;
  logic [CW-1:0]     cap_data;
  logic [1:0]        run_age;

  ccm_table #(.N_ENT(N_ENT), .CW(CW), .AW(AW)) u_table (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_char(rx_char),
    .mask_q(cfg_mask), .s1_valid(s1_valid), .s1_char(s1_char),
    .s1_hit(s1_hit), .s1_rej(s1_rej)
  );

  ccm_pick #(.N_ENT(N_ENT), .CW(CW)) u_pick (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_char(s1_char),
    .s1_hit(s1_hit), .s1_rej(s1_rej), .buf_wr(buf_wr),
    .buf_data(buf_data), .buf_close(buf_close), .irq(irq),
    .cap_load(cap_load), .cap_data(cap_data)
  );

  ccm_capture #(.CW(CW)) u_cap (
    .clk(clk), .rst(rst), .load(cap_load), .data(cap_data),
    .rd(cap_rd), .cap_char(cap_char), .cap_valid(cap_valid),
    .cap_ovr(cap_ovr)
  );

  always_ff @(posedge clk) begin
    if (rst)                run_age <= 2'd0;
    else if (run_age != 2'd3) run_age <= run_age + 2'd1;
  end

  // R12: a strobe two cycles back produces exactly one action now
  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    (run_age >= 2'd2 && $past(rx_valid, 2)) |->
      (buf_wr || (irq && !buf_wr && cap_valid)));

  // R12: store and close never without a strobe two cycles back
  p_no_spurious_r12: assert property (@(posedge clk) disable iff (rst)
    (run_age >= 2'd2 && !$past(rx_valid, 2)) |-> (!buf_wr && !irq && !buf_close));
endmodule

// File: tb/test_ctrl_char_matcher.sv
module test_ctrl_char_matcher;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        cap_rd = 1'b0;
  logic        buf_wr, buf_close, irq, cap_valid, cap_ovr;
  logic [7:0]  buf_data, cap_char;
  logic [15:0] cfg_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit       m_eot [8];
  bit       m_rej [8];
  bit [7:0] m_chr [8];
  bit [15:0] m_mask;
  bit       m_cv, m_co;
  bit [7:0] m_cc;

  always #10 clk = ~clk;

  ctrl_char_matcher i_ctrl_char_matcher (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cap_rd(cap_rd), .buf_wr(buf_wr), .buf_data(buf_data),
    .buf_close(buf_close), .irq(irq), .cap_char(cap_char),
    .cap_valid(cap_valid), .cap_ovr(cap_ovr), .cfg_mask(cfg_mask)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int first_hit(input bit [7:0] ch);
    for (int i = 0; i < 8; i++) begin
      if (m_eot[i]) return -1;
      if (((ch ^ m_chr[i]) & m_mask[7:0]) == 8'h00) return i;
    end
    return -1;
  endfunction

  task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 4'd8) begin
      m_eot[a] = d[15]; m_rej[a] = d[14]; m_chr[a] = d[7:0];
    end else if (a == 4'd8) begin
      m_mask = {2'b11, d[13:0]};
    end
  endtask

  task automatic set_entry(input int i, input bit e, input bit r, input bit [7:0] c);
    cfg_write(4'(i), {e, r, 6'd0, c});
  endtask

  // Drive one character; if rd_with_load, pulse cap_rd so it meets the capture edge.
  task automatic send(input bit [7:0] ch, input bit rd_with_load, input string tag);
    int h;
    bit ewr, ecl, eirq;
    logic [31:0] actv, expv;
    h = first_hit(ch);
    ewr = (h < 0) || !m_rej[h];
    ecl = (h >= 0) && !m_rej[h];
    eirq = (h >= 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = ch;
    @(negedge clk);
    rx_valid = 1'b0;
    // R12: one edge after the strobe nothing has appeared yet
    check(!buf_wr && !irq && !buf_close, "R12 early",
          {29'd0, buf_wr, buf_close, irq}, 32'd0);
    if (rd_with_load) cap_rd = 1'b1;
    @(negedge clk);
    cap_rd = 1'b0;
    if (h >= 0 && m_rej[h]) begin
      m_co = !rd_with_load && (m_co || m_cv);
      m_cv = 1'b1; m_cc = ch;
    end else if (rd_with_load) begin
      m_cv = 1'b0; m_co = 1'b0;
    end
    actv = {buf_wr, buf_close, irq, cap_valid, cap_ovr, 3'd0, cap_char,
            (buf_wr ? buf_data : 8'h00), 8'd0};
    expv = {ewr, ecl, eirq, m_cv, m_co, 3'd0, m_cc,
            (ewr ? ch : 8'h00), 8'd0};
    check(actv == expv, tag, actv, expv);
    @(negedge clk);
    // R12: pulses last one cycle
    check(!buf_wr && !irq && !buf_close, "R12 pulse",
          {29'd0, buf_wr, buf_close, irq}, 32'd0);
  endtask

  function automatic string tag_of(input bit [7:0] ch);
    int h;
    h = first_hit(ch);
    if (h < 0) return "R7 nomatch";
    if (m_rej[h]) return (m_cv ? "R10 overwrite" : "R9 divert");
    return "R8 close";
  endfunction

  task automatic do_read();
    @(negedge clk);
    cap_rd = 1'b1;
    @(negedge clk);
    cap_rd = 1'b0;
    m_cv = 1'b0; m_co = 1'b0;
    check(!cap_valid && !cap_ovr, "R11 read",
          {30'd0, cap_valid, cap_ovr}, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      m_eot[i] = 1'b1; m_rej[i] = 1'b0; m_chr[i] = 8'h00;
    end
    m_mask = 16'hC0FF; m_cv = 1'b0; m_co = 1'b0; m_cc = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state
    check({buf_wr, buf_close, irq, cap_valid, cap_ovr} == 5'd0, "R1 outputs",
          {27'd0, buf_wr, buf_close, irq, cap_valid, cap_ovr}, 32'd0);
    check(cfg_mask == 16'hC0FF, "R1 mask", {16'd0, cfg_mask}, 32'h0000C0FF);
    send(8'h00, 1'b0, "R1 empty table");

    // R2: top mask bits forced
    cfg_write(4'd8, 16'h0000);
    check(cfg_mask == 16'hC000, "R2 mask", {16'd0, cfg_mask}, 32'h0000C000);
    cfg_write(4'd8, 16'h3A5F);
    check(cfg_mask == 16'hFA5F, "R2 mask", {16'd0, cfg_mask}, 32'h0000FA5F);
    cfg_write(4'd8, 16'h00FF);

    // R3: unused addresses ignored
    set_entry(0, 1'b0, 1'b0, 8'h41);
    set_entry(1, 1'b1, 1'b0, 8'h00);
    for (int a = 9; a < 16; a++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'h0000;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    check(cfg_mask == 16'hC0FF, "R3 ignored mask", {16'd0, cfg_mask}, 32'h0000C0FF);
    send(8'h41, 1'b0, "R3 entry kept");
    send(8'h00, 1'b0, "R3 entry kept");

    // R6: priority among duplicates
    set_entry(0, 1'b0, 1'b0, 8'h55);
    set_entry(1, 1'b0, 1'b1, 8'h55);
    set_entry(2, 1'b1, 1'b0, 8'h00);
    send(8'h55, 1'b0, "R6 lowest wins");
    set_entry(0, 1'b0, 1'b1, 8'h55);
    set_entry(1, 1'b0, 1'b0, 8'h55);
    send(8'h55, 1'b0, "R6 lowest wins");
    do_read();

    // R4: end marker hides later entries
    set_entry(0, 1'b1, 1'b0, 8'h10);
    set_entry(1, 1'b0, 1'b0, 8'h42);
    send(8'h42, 1'b0, "R4 after end");
    send(8'h10, 1'b0, "R4 end entry");

    // R5: masked bit ignored
    set_entry(0, 1'b0, 1'b0, 8'h41);
    set_entry(1, 1'b1, 1'b0, 8'h00);
    cfg_write(4'd8, 16'h00DF);
    send(8'h61, 1'b0, "R5 masked match");
    send(8'h40, 1'b0, "R5 compared bit");
    cfg_write(4'd8, 16'h00FF);
    send(8'h61, 1'b0, "R5 full compare");

    // R9, R10, R11: capture register
    set_entry(0, 1'b0, 1'b1, 8'h03);
    cfg_write(4'd8, 16'h00FC);
    send(8'h03, 1'b0, "R9 divert");
    send(8'h02, 1'b0, "R10 overwrite");
    check(cap_ovr && cap_char == 8'h02, "R10 sticky",
          {23'd0, cap_ovr, cap_char}, {23'd0, 1'b1, 8'h02});
    send(8'h44, 1'b0, "R10 sticky after store");
    do_read();
    send(8'h01, 1'b0, "R9 divert");
    send(8'h00, 1'b1, "R11 read with capture");
    do_read();
    cfg_write(4'd8, 16'h00FF);

    // Random phase
    for (int round = 0; round < 60; round++) begin
      int n;
      n = $urandom_range(0, 8);
      for (int i = 0; i < 8; i++) begin
        bit e;
        e = (i == n) ? 1'b1 : ((i > n) ? 1'($urandom_range(0, 1)) : 1'b0);
        set_entry(i, e, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
      end
      if ($urandom_range(0, 3) == 0)
        cfg_write(4'd8, 16'($urandom_range(0, 65535)));
      else
        cfg_write(4'd8, 16'h00FF);
      for (int k = 0; k < 8; k++) begin
        bit [7:0] ch;
        int pick;
        pick = $urandom_range(0, 7);
        if (pick < 5)
          ch = m_chr[pick] ^ (8'($urandom_range(0, 255)) & ~m_mask[7:0]);
        else
          ch = 8'($urandom_range(0, 255));
        send(ch, ($urandom_range(0, 7) == 0), tag_of(ch));
        if ($urandom_range(0, 5) == 0) do_read();
      end
    end

    finish_run();
  end
endmodule